// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is an on-chip trace sink. It accepts 32-bit trace words over a valid/ready stream and writes each one into a circular word RAM at the write pointer. When the pointer passes the last location it wraps to zero and a sticky full flag records that older data has been overwritten. A single-cycle trigger pulse can arm a countdown, after which capture halts a programmed number of words later. A self-clearing manual flush fills the current partial 4-word frame with zero words and can also halt capture when it completes.

Software controls the block through a small register bus with one cycle of read latency. It can read the RAM depth, the status and both pointers, and load either pointer. A read-data register returns the word at the read pointer and steps that pointer. A write-data register stores a word at the write pointer and steps that pointer, which is how software clears the RAM. Capture is re-armed by setting the enable bit while it is clear. Re-arming clears the full flag, the halt and any trigger countdown.

Top module: `trace_capture_buffer`

## Requirements
- R1: After reset `trc_ready` is 0, both pointers and the status register read 0, and the depth register (0x004) reads DEPTH.
- R2: Control register 0x020 bit 0 enables capture. While it is 0, `trc_ready` is 0 and no trace word is stored.
- R3: Each accepted trace word (`trc_valid` and `trc_ready` high at a clock edge) is stored at the write pointer, and the pointer then steps by one modulo DEPTH.
- R4: Status register 0x00C bit 0 sets when a capture write lands in location DEPTH-1. It stays set, even when capture is disabled, until a write of 1 to control bit 0 while that bit is 0 (re-arm).
- R5: A bus read of 0x010 returns the word at the read pointer on the next cycle, and the read pointer then steps by one modulo DEPTH.
- R6: A bus write to 0x024 stores the data at the write pointer and steps that pointer. Writes to 0x014 and 0x018 load the read and write pointers, which count in words.
- R7: With flush-control register 0x304 bit 13 set, a trigger pulse while capturing loads the value of 0x01C. Exactly that many further words are then accepted and capture halts. The word accepted in the trigger cycle is not counted.
- R8: With 0x304 bit 13 clear, a trigger pulse has no effect on capture.
- R9: Writing 1 to 0x304 bit 6 starts a flush. Bit 6 reads back as 1 until the flush ends, then as 0. While the flush runs, trace input is blocked and zero words are written until the write pointer is a multiple of 4.
- R10: If 0x304 bit 12 is set when a flush ends, capture halts. If bit 12 is clear, capture resumes.
- R11: Flush-status register 0x300 bit 1 reads 1 exactly when capture is disabled or halted. Bit 0 reads 1 while a flush runs.
- R12: `trc_ready` is 0 in any cycle in which the bus writes 0x018 or 0x024, so bus and capture never both move the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the read strobe |
| trc_valid | input | 1 | Trace word present |
| trc_data | input | DATA_W | Trace word |
| trc_trigger | input | 1 | Single-cycle trigger pulse |
| trc_ready | output | 1 | Trace word will be accepted at this edge |

## Verification
The assertions assume that each bus access is a one-cycle strobe with a stable address. They also assume that software does not load the write pointer or use the write-data port while a flush is padding. The bench drives bus accesses one at a time, separated by idle cycles, and waits for a flush to end before touching the pointers. Trigger pulses are one cycle wide and are sent only in the first cycle of a burst, so each arming event is unambiguous.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam int BUS_AW = 12;

  localparam logic [BUS_AW-1:0] OFS_DEPTH = 12'h004;
  localparam logic [BUS_AW-1:0] OFS_STAT  = 12'h00C;
  localparam logic [BUS_AW-1:0] OFS_RDAT  = 12'h010;
  localparam logic [BUS_AW-1:0] OFS_RPTR  = 12'h014;
  localparam logic [BUS_AW-1:0] OFS_WPTR  = 12'h018;
  localparam logic [BUS_AW-1:0] OFS_TRIG  = 12'h01C;
  localparam logic [BUS_AW-1:0] OFS_CTRL  = 12'h020;
  localparam logic [BUS_AW-1:0] OFS_WDAT  = 12'h024;
  localparam logic [BUS_AW-1:0] OFS_FSTAT = 12'h300;
  localparam logic [BUS_AW-1:0] OFS_FCTRL = 12'h304;

  localparam int FC_FMT      = 0;
  localparam int FC_FLUSH    = 6;
  localparam int FC_STOP_FL  = 12;
  localparam int FC_STOP_TRG = 13;

  localparam int FS_BUSY    = 0;
  localparam int FS_STOPPED = 1;

  localparam int FRAME_WORDS = 4;

  typedef struct packed {
    logic fmt_en;
    logic stop_flush;
    logic stop_trig;
  } fctl_t;
endpackage

// File: rtl/tcb_store.sv
module tcb_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_word
      logic hit;
      assign hit = we && (waddr == PTR_W'(g));
      always_ff @(posedge clk) begin
        if (hit) mem[g] <= wdata;
      end
    end
  endgenerate

  assign rdata = mem[raddr];
endmodule

// File: rtl/tcb_capture.sv
module tcb_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_stop_trig,
  input  logic             cfg_stop_flush,
  input  logic [CNT_W-1:0] cfg_trg,
  input  logic             rearm,
  input  logic             flush_req,
  input  logic             bus_block,
  input  logic             trig_in,
  input  logic             valid_in,
  input  logic [1:0]       wptr_lo,
  output logic             ready,
  output logic             accept,
  output logic             pad_we,
  output logic             flush_busy,
  output logic             halted
);
  logic             halted_q, halted_d;
  logic             flush_q, flush_d;
  logic             arm_q, arm_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic             capturing, trig_done, aligned, flush_end, trig_load;

  always_comb begin
    capturing = cfg_en && !halted_q;
    trig_done = arm_q && (remain_q == '0);
    aligned   = (wptr_lo == 2'(0));
    ready     = capturing && !flush_q && !trig_done && !bus_block;
    accept    = valid_in && ready;
    pad_we    = flush_q && capturing && !aligned && !bus_block;
    flush_end = flush_q && (!capturing || aligned);
    trig_load = !arm_q && trig_in && capturing && cfg_stop_trig;

    halted_d = halted_q;
    if (rearm) halted_d = 1'b0;
    else if (trig_done || (flush_end && capturing && cfg_stop_flush)) halted_d = 1'b1;

    flush_d = flush_q;
    if (flush_req) flush_d = 1'b1;
    else if (flush_end) flush_d = 1'b0;

    arm_d    = arm_q;
    remain_d = remain_q;
    if (rearm) begin
      arm_d    = 1'b0;
      remain_d = '0;
    end else if (trig_load) begin
      arm_d    = 1'b1;
      remain_d = cfg_trg;
    end else if (arm_q && accept && (remain_q != '0)) begin
      remain_d = remain_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      flush_q  <= 1'b0;
      arm_q    <= 1'b0;
      remain_q <= '0;
    end else begin
      halted_q <= halted_d;
      flush_q  <= flush_d;
      arm_q    <= arm_d;
      remain_q <= remain_d;
    end
  end

  assign flush_busy = flush_q;
  assign halted     = halted_q;
endmodule

// File: rtl/tcb_regs.sv
module tcb_regs
  import tcb_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              cap_we,
  input  logic              flush_busy,
  input  logic              halted,
  output logic              cfg_en,
  output fctl_t             cfg_fc,
  output logic [CNT_W-1:0]  cfg_trg,
  output logic              rearm,
  output logic              flush_req,
  output logic              bus_block,
  output logic              wd_we,
  output logic [PTR_W-1:0]  wptr,
  output logic [PTR_W-1:0]  rptr,
  output logic              full
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic              en_q, en_d;
  fctl_t             fc_q, fc_d;
  logic [CNT_W-1:0]  trg_q, trg_d;
  logic [PTR_W-1:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic              full_q, full_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              wr, rd;

  always_comb begin
    wr        = bus_sel && bus_wr;
    rd        = bus_sel && !bus_wr;
    wd_we     = wr && (bus_addr == OFS_WDAT);
    bus_block = wr && ((bus_addr == OFS_WDAT) || (bus_addr == OFS_WPTR));
    rearm     = wr && (bus_addr == OFS_CTRL) && bus_wdata[0] && !en_q;
    flush_req = wr && (bus_addr == OFS_FCTRL) && bus_wdata[FC_FLUSH];

    en_d  = en_q;
    fc_d  = fc_q;
    trg_d = trg_q;
    if (wr && (bus_addr == OFS_CTRL)) en_d = bus_wdata[0];
    if (wr && (bus_addr == OFS_TRIG)) trg_d = bus_wdata[CNT_W-1:0];
    if (wr && (bus_addr == OFS_FCTRL)) begin
      fc_d.fmt_en     = bus_wdata[FC_FMT];
      fc_d.stop_flush = bus_wdata[FC_STOP_FL];
      fc_d.stop_trig  = bus_wdata[FC_STOP_TRG];
    end

    wptr_d = wptr_q;
    if (wr && (bus_addr == OFS_WPTR)) wptr_d = bus_wdata[PTR_W-1:0];
    else if (wd_we || cap_we) wptr_d = wptr_q + 1'b1;

    rptr_d = rptr_q;
    if (wr && (bus_addr == OFS_RPTR)) rptr_d = bus_wdata[PTR_W-1:0];
    else if (rd && (bus_addr == OFS_RDAT)) rptr_d = rptr_q + 1'b1;

    full_d = full_q;
    if (rearm) full_d = 1'b0;
    else if (cap_we && (wptr_q == LAST)) full_d = 1'b1;

    rdata_d = rdata_q;
    if (rd) begin
      rdata_d = '0;
      case (bus_addr)
        OFS_DEPTH: rdata_d = DATA_W'(DEPTH);
        OFS_STAT:  rdata_d[0] = full_q;
        OFS_RDAT:  rdata_d = mem_rdata;
        OFS_RPTR:  rdata_d = DATA_W'(rptr_q);
        OFS_WPTR:  rdata_d = DATA_W'(wptr_q);
        OFS_TRIG:  rdata_d = DATA_W'(trg_q);
        OFS_CTRL:  rdata_d[0] = en_q;
        OFS_FSTAT: begin
          rdata_d[FS_BUSY]    = flush_busy;
          rdata_d[FS_STOPPED] = !en_q || halted;
        end
        OFS_FCTRL: begin
          rdata_d[FC_FMT]      = fc_q.fmt_en;
          rdata_d[FC_FLUSH]    = flush_busy;
          rdata_d[FC_STOP_FL]  = fc_q.stop_flush;
          rdata_d[FC_STOP_TRG] = fc_q.stop_trig;
        end
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      fc_q    <= '0;
      trg_q   <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
      full_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      en_q    <= en_d;
      fc_q    <= fc_d;
      trg_q   <= trg_d;
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      full_q  <= full_d;
      rdata_q <= rdata_d;
    end
  end

  assign cfg_en    = en_q;
  assign cfg_fc    = fc_q;
  assign cfg_trg   = trg_q;
  assign wptr      = wptr_q;
  assign rptr      = rptr_q;
  assign full      = full_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/trace_capture_buffer.sv
module trace_capture_buffer
  import tcb_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [11:0]       bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              trc_valid,
  input  logic [DATA_W-1:0] trc_data,
  input  logic              trc_trigger,
  output logic              trc_ready
);
  localparam int PTR_W = $clog2(DEPTH);

  logic rst_meta, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      srst_n   <= rst_meta;
    end
  end

  logic              cfg_en, rearm, flush_req, bus_block, wd_we, full;
  fctl_t             cfg_fc;
  logic [CNT_W-1:0]  cfg_trg;
  logic [PTR_W-1:0]  wptr, rptr;
  logic              accept, pad_we, flush_busy, halted, cap_we, mem_we;
  logic [DATA_W-1:0] mem_rdata, mem_wdata;

  assign cap_we    = accept || pad_we;
  assign mem_we    = wd_we || cap_we;
  assign mem_wdata = wd_we ? bus_wdata : (pad_we ? '0 : trc_data);

  tcb_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(srst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_rdata(mem_rdata), .cap_we(cap_we),
    .flush_busy(flush_busy), .halted(halted),
    .cfg_en(cfg_en), .cfg_fc(cfg_fc), .cfg_trg(cfg_trg),
    .rearm(rearm), .flush_req(flush_req), .bus_block(bus_block),
    .wd_we(wd_we), .wptr(wptr), .rptr(rptr), .full(full)
  );

  tcb_capture #(.CNT_W(CNT_W)) u_capture (
    .clk(clk), .rst_n(srst_n),
    .cfg_en(cfg_en), .cfg_stop_trig(cfg_fc.stop_trig),
    .cfg_stop_flush(cfg_fc.stop_flush), .cfg_trg(cfg_trg),
    .rearm(rearm), .flush_req(flush_req), .bus_block(bus_block),
    .trig_in(trc_trigger), .valid_in(trc_valid), .wptr_lo(wptr[1:0]),
    .ready(trc_ready), .accept(accept), .pad_we(pad_we),
    .flush_busy(flush_busy), .halted(halted)
  );

  tcb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(wptr), .wdata(mem_wdata),
    .raddr(rptr), .rdata(mem_rdata)
  );
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker
  import tcb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [11:0]       bus_addr,
  input logic              trc_ready,
  input logic              cfg_en,
  input logic              cap_we,
  input logic              rearm,
  input logic              full,
  input logic              flush_busy,
  input logic              halted,
  input logic [PTR_W-1:0]  wptr,
  input logic [PTR_W-1:0]  rptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  assert_ready_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> !trc_ready);

  assert_wptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we |=> wptr == PTR_W'($past(wptr) + 1'b1));

  assert_full_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_we && wptr == LAST) |=> full);

  assert_full_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rearm) |=> full);

  assert_rptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == OFS_RDAT) |=> rptr == PTR_W'($past(rptr) + 1'b1));

  assert_halt_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !trc_ready);

  assert_flush_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> !trc_ready);

  assert_bus_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (bus_addr == OFS_WPTR || bus_addr == OFS_WDAT)) |-> !trc_ready);
endmodule

bind trace_capture_buffer tcb_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_tcb_checker (
  .clk(clk), .rst_n(srst_n),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .trc_ready(trc_ready), .cfg_en(cfg_en), .cap_we(cap_we),
  .rearm(rearm), .full(full), .flush_busy(flush_busy), .halted(halted),
  .wptr(wptr), .rptr(rptr)
);

// File: tb/test_trace_capture_buffer.sv
`timescale 1ns/1ps
module test_trace_capture_buffer;
  localparam int DEPTH = 64;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_wr;
  logic [11:0]   bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          trc_valid, trc_trigger, trc_ready;
  logic [DW-1:0] trc_data;

  int n_chk = 0;
  int n_fail = 0;
  logic ready_in_write;

  always #4 clk = ~clk;

  trace_capture_buffer #(.DEPTH(DEPTH), .DATA_W(DW), .CNT_W(16)) i_trace_capture_buffer (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trc_valid(trc_valid), .trc_data(trc_data), .trc_trigger(trc_trigger),
    .trc_ready(trc_ready)
  );

  // {is_write, offset, write data, expected read data}
  localparam logic [76:0] VEC [14] = '{
    {1'b0, 12'h004, 32'h0, 32'd64},
    {1'b0, 12'h00C, 32'h0, 32'h0},
    {1'b0, 12'h014, 32'h0, 32'h0},
    {1'b0, 12'h018, 32'h0, 32'h0},
    {1'b0, 12'h020, 32'h0, 32'h0},
    {1'b0, 12'h300, 32'h0, 32'h2},
    {1'b1, 12'h01C, 32'h5, 32'h0},
    {1'b0, 12'h01C, 32'h0, 32'h5},
    {1'b1, 12'h018, 32'h3, 32'h0},
    {1'b0, 12'h018, 32'h0, 32'h3},
    {1'b1, 12'h014, 32'h7, 32'h0},
    {1'b0, 12'h014, 32'h0, 32'h7},
    {1'b1, 12'h304, 32'h3001, 32'h0},
    {1'b0, 12'h304, 32'h0, 32'h3001}
  };

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1 ready_in_write = trc_ready;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_words(input int n, input logic [DW-1:0] base, input bit trig_first,
                            output int acc);
    acc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trc_valid = 1'b1; trc_data = base + DW'(i); trc_trigger = trig_first && (i == 0);
      #1 if (trc_ready) acc++;
      @(posedge clk);
    end
    @(negedge clk);
    trc_valid = 1'b0; trc_trigger = 1'b0;
  endtask

  task automatic rearm();
    bus_write(12'h020, 32'h0);
    bus_write(12'h020, 32'h1);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] rv;
    int acc;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    trc_valid = 1'b0; trc_data = '0; trc_trigger = 1'b0; ready_in_write = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ready after reset", DW'(trc_ready), 0);

    for (int v = 0; v < 14; v++) begin
      if (VEC[v][76]) bus_write(VEC[v][75:64], VEC[v][63:32]);
      else begin
        bus_read(VEC[v][75:64], rv);
        check($sformatf("R1/R6/R11 table vector %0d", v), rv, VEC[v][31:0]);
      end
    end
    bus_write(12'h018, 0); bus_write(12'h014, 0);
    bus_write(12'h304, 0); bus_write(12'h01C, 0);

    // R2: disabled capture stores nothing
    send_words(3, 32'hDEAD0000, 1'b0, acc);
    check("R2 words accepted while disabled", DW'(acc), 0);
    bus_read(12'h018, rv); check("R2 wptr unchanged while disabled", rv, 0);
    bus_write(12'h020, 32'h1);
    #1 check("R2 ready after enable", DW'(trc_ready), 1);
    bus_read(12'h300, rv); check("R11 running flush status", rv, 0);

    // R3 / R5: capture then read back
    send_words(5, 32'hC0DE0000, 1'b0, acc);
    check("R3 accepted count", DW'(acc), 5);
    bus_read(12'h018, rv); check("R3 wptr after five words", rv, 5);
    for (int i = 0; i < 5; i++) begin
      bus_read(12'h010, rv); check("R5 read data word", rv, 32'hC0DE0000 + DW'(i));
    end
    bus_read(12'h014, rv); check("R5 rptr after reads", rv, 5);

    // R6 / R12: write-data port
    bus_write(12'h018, 10);
    bus_write(12'h024, 32'hAAAA0001);
    check("R12 ready low during data-port write", DW'(ready_in_write), 0);
    bus_write(12'h024, 32'hBBBB0002);
    bus_read(12'h018, rv); check("R6 wptr after port writes", rv, 12);
    bus_write(12'h014, 10);
    bus_read(12'h010, rv); check("R6 first port word", rv, 32'hAAAA0001);
    bus_read(12'h010, rv); check("R6 second port word", rv, 32'hBBBB0002);

    // R9: flush pads 5..7 with zeros
    bus_write(12'h018, 5);
    for (int i = 0; i < 3; i++) bus_write(12'h024, 32'h11110000 + DW'(i));
    bus_write(12'h018, 5);
    bus_write(12'h304, 32'h40);
    bus_read(12'h304, rv); check("R9 flush bit reads 1 while busy", rv, 32'h40);
    repeat (8) @(negedge clk);
    bus_read(12'h304, rv); check("R9 flush bit self-clears", rv, 0);
    bus_read(12'h018, rv); check("R9 wptr padded to frame", rv, 8);
    bus_write(12'h014, 5);
    for (int i = 0; i < 3; i++) begin
      bus_read(12'h010, rv); check("R9 pad word is zero", rv, 0);
    end
    #1 check("R10 capture resumes without stop-on-flush", DW'(trc_ready), 1);

    // R10: stop on flush
    bus_write(12'h304, 32'h1041);
    repeat (3) @(negedge clk);
    check("R10 ready low after stop-on-flush", DW'(trc_ready), 0);
    bus_read(12'h300, rv); check("R11 stopped after flush halt", rv, 2);
    bus_read(12'h304, rv); check("R10 control readback", rv, 32'h1001);
    rearm();

    // R7: stop after trigger count
    bus_write(12'h304, 32'h2000);
    bus_write(12'h01C, 3);
    bus_write(12'h018, 0);
    send_words(10, 32'h7E000000, 1'b1, acc);
    check("R7 words accepted with count 3", DW'(acc), 4);
    check("R7 ready low after count", DW'(trc_ready), 0);
    bus_read(12'h018, rv); check("R7 wptr after trigger stop", rv, 4);
    bus_read(12'h300, rv); check("R11 stopped after trigger halt", rv, 2);
    rearm();
    bus_write(12'h01C, 0);
    send_words(5, 32'h7F000000, 1'b1, acc);
    check("R7 words accepted with count 0", DW'(acc), 1);
    rearm();

    // R8: trigger ignored when stop-on-trigger clear
    bus_write(12'h304, 32'h0);
    bus_write(12'h01C, 1);
    send_words(6, 32'h80000000, 1'b1, acc);
    check("R8 all words accepted", DW'(acc), 6);
    #1 check("R8 ready still high", DW'(trc_ready), 1);

    // R4: full flag
    bus_write(12'h018, DEPTH - 2);
    bus_read(12'h00C, rv); check("R4 status clear before wrap", rv, 0);
    send_words(2, 32'hF0000000, 1'b0, acc);
    bus_read(12'h00C, rv); check("R4 full after wrap", rv, 1);
    bus_read(12'h018, rv); check("R4 wptr wrapped", rv, 0);
    send_words(1, 32'hF1000000, 1'b0, acc);
    bus_write(12'h020, 32'h0);
    bus_read(12'h00C, rv); check("R4 full held while disabled", rv, 1);
    bus_write(12'h020, 32'h1);
    bus_read(12'h00C, rv); check("R4 full cleared by re-arm", rv, 0);
    bus_write(12'h014, DEPTH - 1);
    bus_read(12'h010, rv); check("R3 word at last location", rv, 32'hF0000001);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule